// File: doc/BRIEF.md
# Free-Running Compare Timer

This block is a memory-mapped general-purpose timer. Its core is an up-counter that keeps running through wraparound. A single compare channel raises a status flag when the counter reaches a programmed value. The flag can be routed to a level-sensitive interrupt. Software schedules an event by reading the counter, adding a delta and writing the sum to the compare register. In free-run mode the count is not disturbed by a match. In restart mode the count drops back to zero on the tick after a match, which gives a periodic timebase.

The counter does not count clock edges directly. It counts ticks from a selected source. The sources are three tick-enable inputs: one from the bus clock domain, one from a peripheral clock and one from a crystal oscillator. The crystal input passes through its own small prescaler. The tick that is selected then goes through a 12-bit main prescaler. A simple register bus gives access to the registers. It has an address, a write enable, write data and combinational read data.

Top module: `cmp_timer`

## Requirements
- R1: After reset every register reads 0 and `irqOut` is low. Writing 0 to control (0x00) and 0 to prescaler (0x04) leaves the counter stopped.
- R2: Register map. Control at 0x00 keeps only bit 0 (run), bit 3 (wait enable, stored only), bits [8:6] (source), bit 9 (free-run) and bit 10 (crystal path enable). Prescaler at 0x04 keeps the main divider in [11:0] and the crystal divider in [15:12]. Status at 0x08 bit 0, interrupt enable at 0x0C bit 0, compare at 0x10, counter at 0x24. Bits that are not stored, and unmapped addresses, read 0.
- R3: While running, the counter advances by exactly 1 per divided tick, modulo 2^32.
- R4: A main divider value P yields one divided tick per P+1 selected ticks.
- R5: Source encoding 1 selects `busTick`, 2 selects `perTick` and 5 selects the crystal path. Any other encoding produces no ticks.
- R6: With the crystal path enabled, a crystal divider value N passes one of every N+1 `xtalTick` pulses. With the crystal path disabled, every `xtalTick` pulse passes.
- R7: The status flag sets on the clock edge where the counter advances to the compare value. In free-run mode counting continues past the match.
- R8: In restart mode (free-run bit 0), the tick after a match loads the counter with 0 instead of compare+1.
- R9: Writing 1 to status bit 0 clears the flag, and writing 0 leaves it unchanged. A new match in the same cycle as a clear wins.
- R10: `irqOut` is the flag ANDed with the interrupt enable bit. It is a level that holds until the flag is cleared or masked.
- R11: Clearing the run bit freezes the counter. Setting it again from 0 zeroes the counter and both prescalers before counting resumes.
- R12: Writes to the counter address have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busTick | input | 1 | Bus-clock tick enable (source 1) |
| perTick | input | 1 | Peripheral-clock tick enable (source 2) |
| xtalTick | input | 1 | Crystal tick enable, feeds the crystal prescaler (source 5) |
| regAddr | input | 8 | Register byte address |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Combinational read data for `regAddr` |
| irqOut | output | 1 | Level interrupt: flag AND enable |

## Verification
Register writes take effect at the clock edge that samples them. A write of the run bit therefore leaves the counter at 0 right after that edge. With an undivided tick held high, the counter reads N after N further edges. The status flag rises on the same edge at which the counter reaches the compare value. `irqOut` follows a write to the interrupt enable register one edge later. Read data is combinational, so the bench drives on the falling edge and samples read data and `irqOut` half a cycle after an edge. It derives every expected count from the number of edges elapsed since the enabling write, divided by the programmed ratios. For the periodic peripheral tick it compares counter deltas over a whole number of tick periods.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int CNT_W   = 32;
  localparam int ADDR_W  = 8;
  localparam int MPRE_W  = 12;
  localparam int XPRE_W  = 4;
  localparam int SRC_W   = 3;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_PRE  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_IE   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_CMP  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 8'h24;

  // control field positions
  localparam int B_RUN   = 0;
  localparam int B_WAIT  = 3;
  localparam int B_SRC   = 6;
  localparam int B_FREE  = 9;
  localparam int B_XEN   = 10;
  localparam int B_XPRE  = 12;

  typedef enum logic [SRC_W-1:0] {
    SRC_NONE = 3'd0,
    SRC_BUS  = 3'd1,
    SRC_PER  = 3'd2,
    SRC_XTAL = 3'd5
  } tickSrc_e;

  typedef struct packed {
    logic              run;
    logic [SRC_W-1:0]  src;
    logic              freeRun;
    logic              xtalEn;
    logic [MPRE_W-1:0] mainPre;
    logic [XPRE_W-1:0] xtalPre;
    logic [CNT_W-1:0]  cmpVal;
  } dpCfg_t;

  typedef struct packed {
    logic restart;
    logic clrFlag;
  } dpStrobe_t;
endpackage

// File: rtl/cmp_timer_ctrl.sv
module cmp_timer_ctrl
  import cmp_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic              flagSt,
  output logic              ieBit,
  output dpCfg_t            cfg,
  output dpStrobe_t         stb
);
  logic waitEn;

  logic wrCtrl, wrPre, wrStat, wrIe, wrCmp;
  assign wrCtrl = regWe && (regAddr == OFS_CTRL);
  assign wrPre  = regWe && (regAddr == OFS_PRE);
  assign wrStat = regWe && (regAddr == OFS_STAT);
  assign wrIe   = regWe && (regAddr == OFS_IE);
  assign wrCmp  = regWe && (regAddr == OFS_CMP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg    <= '0;
      waitEn <= 1'b0;
      ieBit  <= 1'b0;
    end else begin
      if (wrCtrl) begin
        cfg.run     <= regWdata[B_RUN];
        waitEn      <= regWdata[B_WAIT];
        cfg.src     <= regWdata[B_SRC +: SRC_W];
        cfg.freeRun <= regWdata[B_FREE];
        cfg.xtalEn  <= regWdata[B_XEN];
      end
      if (wrPre) begin
        cfg.mainPre <= regWdata[MPRE_W-1:0];
        cfg.xtalPre <= regWdata[B_XPRE +: XPRE_W];
      end
      if (wrIe)  ieBit      <= regWdata[0];
      if (wrCmp) cfg.cmpVal <= regWdata[CNT_W-1:0];
    end
  end

  always_comb begin
    stb         = '0;
    stb.restart = wrCtrl && regWdata[B_RUN] && !cfg.run;
    stb.clrFlag = wrStat && regWdata[0];
  end

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      OFS_CTRL: begin
        regRdata[B_RUN]           = cfg.run;
        regRdata[B_WAIT]          = waitEn;
        regRdata[B_SRC +: SRC_W]  = cfg.src;
        regRdata[B_FREE]          = cfg.freeRun;
        regRdata[B_XEN]           = cfg.xtalEn;
      end
      OFS_PRE: begin
        regRdata[MPRE_W-1:0]      = cfg.mainPre;
        regRdata[B_XPRE +: XPRE_W] = cfg.xtalPre;
      end
      OFS_STAT: regRdata[0]          = flagSt;
      OFS_IE:   regRdata[0]          = ieBit;
      OFS_CMP:  regRdata[CNT_W-1:0]  = cfg.cmpVal;
      OFS_CNT:  regRdata[CNT_W-1:0]  = cntVal;
      default:  regRdata             = '0;
    endcase
  end
endmodule

// File: rtl/cmp_timer_dp.sv
module cmp_timer_dp
  import cmp_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busTick,
  input  logic             perTick,
  input  logic             xtalTick,
  input  dpCfg_t           cfg,
  input  dpStrobe_t        stb,
  output logic [CNT_W-1:0] cntVal,
  output logic             flagSt,
  output logic             divTick
);
  logic [XPRE_W-1:0] xtalCnt;
  logic [MPRE_W-1:0] preCnt;
  logic              xtalHit, xtalDiv, selTick;
  logic [CNT_W-1:0]  nextCnt;

  // crystal path: own divider when enabled, bypass otherwise
  assign xtalHit = (xtalCnt == cfg.xtalPre);
  assign xtalDiv = xtalTick && (cfg.xtalEn ? xtalHit : 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  xtalCnt <= '0;
    else if (stb.restart)                       xtalCnt <= '0;
    else if (cfg.run && cfg.xtalEn && xtalTick) xtalCnt <= xtalHit ? '0 : xtalCnt + 1'b1;
  end

  always_comb begin
    unique case (cfg.src)
      SRC_BUS:  selTick = busTick;
      SRC_PER:  selTick = perTick;
      SRC_XTAL: selTick = xtalDiv;
      default:  selTick = 1'b0;
    endcase
  end

  // main prescaler
  assign divTick = cfg.run && selTick && (preCnt == cfg.mainPre);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    preCnt <= '0;
    else if (stb.restart)         preCnt <= '0;
    else if (cfg.run && selTick)  preCnt <= (preCnt == cfg.mainPre) ? '0 : preCnt + 1'b1;
  end

  // counter and compare
  assign nextCnt = (!cfg.freeRun && (cntVal == cfg.cmpVal)) ? '0 : cntVal + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cntVal <= '0;
    else if (stb.restart) cntVal <= '0;
    else if (divTick)     cntVal <= nextCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  flagSt <= 1'b0;
    else if (divTick && nextCnt == cfg.cmpVal)  flagSt <= 1'b1;
    else if (stb.clrFlag)                       flagSt <= 1'b0;
  end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busTick,
  input  logic              perTick,
  input  logic              xtalTick,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              irqOut
);
  dpCfg_t           cfg;
  dpStrobe_t        stb;
  logic [CNT_W-1:0] cntVal;
  logic             flagSt, ieBit, divTick;

  cmp_timer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .cntVal(cntVal),
    .flagSt(flagSt), .ieBit(ieBit), .cfg(cfg), .stb(stb)
  );

  cmp_timer_dp u_dp (
    .clk(clk), .rstN(rstN), .busTick(busTick), .perTick(perTick),
    .xtalTick(xtalTick), .cfg(cfg), .stb(stb), .cntVal(cntVal),
    .flagSt(flagSt), .divTick(divTick)
  );

  assign irqOut = flagSt && ieBit;
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk
  import cmp_timer_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             irqOut,
  input logic [CNT_W-1:0] cntVal,
  input logic             flagSt,
  input logic             divTick,
  input dpCfg_t           cfg,
  input dpStrobe_t        stb
);
  p_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    divTick && !stb.restart && cfg.freeRun |=> cntVal == $past(cntVal) + CNT_W'(1));

  p_freeze_r11: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.run && !stb.restart |=> $stable(cntVal));

  p_restart_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    stb.restart |=> cntVal == '0);

  p_wrap_to_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    divTick && !stb.restart && !cfg.freeRun && cntVal == cfg.cmpVal |=> cntVal == '0);

  p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    flagSt && !stb.clrFlag |=> flagSt);

  p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> flagSt);
endmodule

bind cmp_timer cmp_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .irqOut(irqOut), .cntVal(cntVal),
  .flagSt(flagSt), .divTick(divTick), .cfg(cfg), .stb(stb)
);

// File: tb/cmp_timer_bench.sv
module cmp_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busTick = 1'b1;
  logic        perTick = 1'b0;
  logic        xtalTick = 1'b1;
  logic [7:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  cmp_timer u_cmp_timer (.*);

  always #2 clk = ~clk;   // 250 MHz

  // peripheral tick: one pulse every third cycle
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      perTick = (ph == 0);
      ph = (ph == 2) ? 0 : ph + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #0.5;
    d = regRdata;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stopAll();
    wr(8'h00, 32'h0);
    wr(8'h04, 32'h0);
  endtask

  // control word: run, source, free-run, crystal enable
  function automatic logic [31:0] ctl(input bit run, input int src, input bit fr, input bit xe);
    return 32'(run) | (32'(src) << 6) | (32'(fr) << 9) | (32'(xe) << 10);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    foreach (d[i]) d[i] = 1'b0;
    rd(8'h00, d); chk("R1 ctrl reset", d, 0);
    rd(8'h04, d); chk("R1 prescaler reset", d, 0);
    rd(8'h08, d); chk("R1 status reset", d, 0);
    rd(8'h24, d); chk("R1 counter reset", d, 0);
    chk("R1 irq reset", irqOut, 0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(8'h00, 32'hFFFF_FFFE);
    rd(8'h00, d); chk("R2 ctrl mask", d, 32'h0000_07C8);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, d); chk("R2 prescaler mask", d, 32'h0000_FFFF);
    wr(8'h10, 32'hA5A5_0F0F);
    rd(8'h10, d); chk("R2 compare rw", d, 32'hA5A5_0F0F);
    rd(8'h30, d); chk("R2 unmapped", d, 0);
    stopAll();
    wr(8'h10, 32'hFFFF_FFFF);
  endtask

  task automatic t_busCount();
    logic [31:0] d;
    stopAll();
    wr(8'h00, ctl(1, 1, 1, 0));
    waitN(10);
    rd(8'h24, d); chk("R3 bus tick count", d, 10);
  endtask

  task automatic t_prescale();
    logic [31:0] d;
    stopAll();
    wr(8'h04, 32'd3);
    wr(8'h00, ctl(1, 1, 1, 0));
    waitN(20);
    rd(8'h24, d); chk("R4 divide by 4", d, 5);
  endtask

  task automatic t_sources();
    logic [31:0] a, b;
    stopAll();
    wr(8'h00, ctl(1, 2, 1, 0));
    rd(8'h24, a); waitN(30); rd(8'h24, b);
    chk("R5 peripheral tick delta", b - a, 10);
    wr(8'h00, ctl(1, 3, 1, 0));
    rd(8'h24, a); waitN(10); rd(8'h24, b);
    chk("R5 unused source no count", b - a, 0);
  endtask

  task automatic t_xtal();
    logic [31:0] a, b;
    stopAll();
    wr(8'h04, 32'h0000_7000);
    wr(8'h00, ctl(1, 5, 1, 1));
    waitN(32);
    rd(8'h24, a); chk("R6 crystal divide by 8", a, 4);
    wr(8'h00, ctl(1, 5, 1, 0));
    rd(8'h24, a); waitN(16); rd(8'h24, b);
    chk("R6 crystal bypass", b - a, 16);
  endtask

  task automatic t_freeze();
    logic [31:0] d;
    stopAll();
    wr(8'h00, ctl(1, 1, 1, 0));
    waitN(5);
    wr(8'h00, ctl(0, 1, 1, 0));
    rd(8'h24, d); chk("R11 count at stop", d, 6);
    waitN(10);
    rd(8'h24, d); chk("R11 frozen", d, 6);
    wr(8'h24, 32'h0000_1234);
    rd(8'h24, d); chk("R12 counter write ignored", d, 6);
    wr(8'h04, 32'h0);
    waitN(5);
    rd(8'h24, d); chk("R1 zero ctrl stays stopped", d, 6);
    wr(8'h00, ctl(1, 1, 1, 0));
    rd(8'h24, d); chk("R11 restart zero", d, 0);
    waitN(3);
    rd(8'h24, d); chk("R11 resumed", d, 3);
  endtask

  task automatic t_compare();
    logic [31:0] d;
    stopAll();
    wr(8'h10, 32'd10);
    wr(8'h0C, 32'd0);
    wr(8'h08, 32'd1);
    wr(8'h00, ctl(1, 1, 1, 0));
    waitN(9);
    rd(8'h08, d); chk("R7 no flag before match", d, 0);
    waitN(1);
    rd(8'h08, d); chk("R7 flag at match", d, 1);
    rd(8'h24, d); chk("R7 count at match", d, 10);
    chk("R10 masked irq", irqOut, 0);
    waitN(5);
    rd(8'h24, d); chk("R7 free-run continues", d, 15);
    wr(8'h0C, 32'd1);
    chk("R10 irq on enable", irqOut, 1);
    wr(8'h0C, 32'd0);
    chk("R10 irq masked", irqOut, 0);
    wr(8'h08, 32'd0);
    rd(8'h08, d); chk("R9 write 0 keeps flag", d, 1);
    wr(8'h08, 32'd1);
    rd(8'h08, d); chk("R9 write 1 clears", d, 0);
  endtask

  task automatic t_restartMode();
    logic [31:0] d;
    stopAll();
    wr(8'h10, 32'd4);
    wr(8'h08, 32'd1);
    wr(8'h00, ctl(1, 1, 0, 0));
    waitN(4);
    rd(8'h24, d); chk("R8 reach compare", d, 4);
    rd(8'h08, d); chk("R8 flag", d, 1);
    waitN(1);
    rd(8'h24, d); chk("R8 back to zero", d, 0);
    waitN(1);
    rd(8'h24, d); chk("R8 counts again", d, 1);
    stopAll();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_busCount();
    t_prescale();
    t_sources();
    t_xtal();
    t_freeze();
    t_compare();
    t_restartMode();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule